// File: doc/BRIEF.md
# Calendar Real-Time Clock with Gated Register Writes

This block keeps wall-clock time and date. It runs from a free-running crystal-rate clock, nominally 32.768 kHz. A prescaler turns that clock into a once-per-second update. The update advances a chain of fields: seconds, minutes, hours, weekday, day of month, month and two-digit year. The day-of-month rollover follows each month's length, including 29-day Februaries in leap years.

A host reaches the clock through a byte-wide register port on its own, unrelated clock. Reads return values from per-field holding registers, and all of those registers are refreshed at once whenever the host reads seconds. Because the counters run on the other clock, software rereads seconds until two reads agree.

Writes are protected. A store to a gate address arms a one-shot enable, and the next register store consumes it. Accepted stores are carried into the clock domain by a toggle handshake, which also enforces a minimum spacing between applied writes. Two correction pulses, synchronous to the crystal-rate clock, let firmware skip a second or insert an extra one at the next update.

Top module: `rtc_cal`

## Requirements
- R1: The fields count seconds 0–59, minutes 0–59, hours 0–23, weekday 1–7, day of month from 1, month 1–12 and year 0–99. Each field wraps to its minimum and carries into the next field, with year 99 wrapping to 0. Reset gives 00:00:00, weekday 1, day 1, month 1, year 0.
- R2: The last day of the month is 30 for months 4, 6, 9 and 11. It is 29 for month 2 when the year is a multiple of 4, 28 for month 2 otherwise, and 31 for every other month.
- R3: The time advances once every TICK_DIV cycles of rtc_clk. An applied write to seconds restarts that interval.
- R4: Register offsets from BASE_ADDR are 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day, 5 month, 6 year and 7 status. A read of offset 0 returns the live seconds and loads the live value of every field into the holding registers. Reads of offsets 1–6 return the holding registers, unchanged by time that has passed since then.
- R5: Every read completes on its second cycle. bus_ready is low in the first cycle of the read and high in the second.
- R6: A write to GATE_ADDR opens the write gate. The gate stays open through reads and writes to other addresses. It closes when one write to offsets 0–6 is accepted.
- R7: A write to offsets 0–6 while the gate is closed completes without wait states and changes no field.
- R8: Applied field writes are at least GAP_TICKS rtc_clk cycles apart. A gated field write issued while the previous one is still in flight is held with bus_ready low until that one has finished.
- R9: The status register at offset 7 reads bit 0 = write in flight and bit 1 = gate open, with all other bits zero.
- R10: A pulse on inc_sec_pulse makes the next update advance time by two seconds, with normal carry into the higher fields.
- R11: A pulse on dec_sec_pulse makes the next update leave the time unchanged.
- R12: If both corrections are pending at the same update, they cancel and time advances by exactly one second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| host_clk | input | 1 | Host bus clock |
| rtc_clk | input | 1 | Crystal-rate clock driving the counters |
| rst | input | 1 | Synchronous active-high reset, held for several cycles of both clocks |
| bus_sel | input | 1 | Access request, held until bus_ready |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_ready is high on a read |
| bus_ready | output | 1 | Access completes on the host_clk edge where bus_sel and bus_ready are high |
| inc_sec_pulse | input | 1 | One rtc_clk cycle pulse: add a second at the next update |
| dec_sec_pulse | input | 1 | One rtc_clk cycle pulse: drop a second at the next update |

## Verification
The calendar chain is exercised by presetting a time just before a boundary, letting exactly one update occur, and then reading every field. The boundaries tried are:
- a bare seconds step and a minute carry;
- a day carry at the end of a 30-day month;
- leap and non-leap February ends, plus the 29th of a leap February;
- a carry across the year from 99 to 0.

Together these separate a wrong month length, a wrong leap rule and a wrong wrap value. The same preset-and-update pattern is repeated with inc-only, dec-only and both pulses, including an inc that crosses a day. This tells double-stepping apart from holding and from cancelling. Separate sequences probe the gate (closed, opened across unrelated accesses, consumed by one write) and the holding registers (a field rewritten without a seconds read). They also probe the hold-off of a second write while the first is in flight, and the restart of the one-second interval by a seconds write.

// File: rtl/rtc_cal_pkg.sv
`timescale 1ns/1ps
package rtc_cal_pkg;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [7:0] wday;
        logic [7:0] mday;
        logic [7:0] month;
        logic [7:0] year;
    } cal_t;

    // Register offsets within the window; the order is the host address map.
    typedef enum logic [2:0] {
        F_SEC   = 3'd0,
        F_MIN   = 3'd1,
        F_HOUR  = 3'd2,
        F_WDAY  = 3'd3,
        F_MDAY  = 3'd4,
        F_MONTH = 3'd5,
        F_YEAR  = 3'd6,
        F_STAT  = 3'd7
    } field_e;

    localparam cal_t CAL_RESET = '{sec: 8'd0, min: 8'd0, hour: 8'd0, wday: 8'd1,
                                   mday: 8'd1, month: 8'd1, year: 8'd0};

    function automatic logic [7:0] month_len(input logic [7:0] month, input logic [7:0] year);
        case (month)
            8'd2:                      return (year[1:0] == 2'b00) ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11:   return 8'd30;
            default:                   return 8'd31;
        endcase
    endfunction

    // Advance a time by one second with full carry through the calendar.
    function automatic cal_t step_second(input cal_t t);
        cal_t n;
        n = t;
        if (t.sec >= 8'd59) begin
            n.sec = 8'd0;
            if (t.min >= 8'd59) begin
                n.min = 8'd0;
                if (t.hour >= 8'd23) begin
                    n.hour = 8'd0;
                    n.wday = (t.wday >= 8'd7) ? 8'd1 : t.wday + 8'd1;
                    if (t.mday >= month_len(t.month, t.year)) begin
                        n.mday = 8'd1;
                        if (t.month >= 8'd12) begin
                            n.month = 8'd1;
                            n.year  = (t.year >= 8'd99) ? 8'd0 : t.year + 8'd1;
                        end else begin
                            n.month = t.month + 8'd1;
                        end
                    end else begin
                        n.mday = t.mday + 8'd1;
                    end
                end else begin
                    n.hour = t.hour + 8'd1;
                end
            end else begin
                n.min = t.min + 8'd1;
            end
        end else begin
            n.sec = t.sec + 8'd1;
        end
        return n;
    endfunction

    function automatic cal_t put_field(input cal_t t, input field_e f, input logic [7:0] v);
        cal_t n;
        n = t;
        case (f)
            F_SEC:   n.sec   = v;
            F_MIN:   n.min   = v;
            F_HOUR:  n.hour  = v;
            F_WDAY:  n.wday  = v;
            F_MDAY:  n.mday  = v;
            F_MONTH: n.month = v;
            F_YEAR:  n.year  = v;
            default: ;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/rtc_cal_sync.sv
`timescale 1ns/1ps
module rtc_cal_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rtc_cal_prescale.sv
`timescale 1ns/1ps
module rtc_cal_prescale #(
    parameter int DIV = 32768
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic strobe
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;
    logic          last;

    assign last   = (cnt == CW'(DIV - 1));
    assign strobe = last && !restart;

    always_ff @(posedge clk) begin
        if (rst || restart || last) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/rtc_cal_core.sv
`timescale 1ns/1ps
module rtc_cal_core
    import rtc_cal_pkg::*;
#(
    parameter int GAP_TICKS   = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   sec_tick,
    input  logic   req_tgl,
    input  field_e wr_field,
    input  logic [7:0] wr_data,
    input  logic   inc_pulse,
    input  logic   dec_pulse,
    output logic   ack_tgl,
    output logic   restart,
    output cal_t   live
);
    localparam int GAP_W = $clog2(GAP_TICKS + 1);

    cal_t now, stepped, doubled, base, nxt;
    logic req_s, req_seen, apply;
    logic inc_pend, dec_pend, eff_inc, eff_dec;
    logic [GAP_W-1:0] gap_cnt;

    rtc_cal_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk (clk), .rst (rst), .d (req_tgl), .q (req_s)
    );

    assign apply   = (req_s != req_seen) && (gap_cnt == '0);
    assign restart = apply && (wr_field == F_SEC);
    assign eff_inc = inc_pend || inc_pulse;
    assign eff_dec = dec_pend || dec_pulse;
    assign live    = now;

    always_comb begin
        stepped = step_second(now);
        doubled = step_second(stepped);
        base    = now;
        if (sec_tick) begin
            case ({eff_inc, eff_dec})
                2'b10:   base = doubled;
                2'b01:   base = now;
                default: base = stepped;
            endcase
        end
        nxt = apply ? put_field(base, wr_field, wr_data) : base;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            now      <= CAL_RESET;
            inc_pend <= 1'b0;
            dec_pend <= 1'b0;
            req_seen <= 1'b0;
            gap_cnt  <= '0;
            ack_tgl  <= 1'b0;
        end else begin
            now      <= nxt;
            inc_pend <= sec_tick ? 1'b0 : eff_inc;
            dec_pend <= sec_tick ? 1'b0 : eff_dec;
            if (apply) begin
                req_seen <= req_s;
                gap_cnt  <= GAP_W'(GAP_TICKS);
            end else if (gap_cnt != '0) begin
                gap_cnt <= gap_cnt - 1'b1;
            end
            if (gap_cnt == GAP_W'(1)) ack_tgl <= req_seen;
        end
    end

    // Cycles since the last applied write, saturating (assertion support).
    logic [GAP_W-1:0] since_apply;
    always_ff @(posedge clk) begin
        if (rst)                                  since_apply <= GAP_W'(GAP_TICKS);
        else if (apply)                           since_apply <= GAP_W'(1);
        else if (since_apply != GAP_W'(GAP_TICKS)) since_apply <= since_apply + 1'b1;
    end

    p_write_spacing_r8: assert property (@(posedge clk) disable iff (rst)
        apply |-> since_apply >= GAP_W'(GAP_TICKS));

    p_inc_double_r10: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && eff_inc && !eff_dec && !apply && now.sec < 8'd58)
        |=> now.sec == $past(now.sec) + 8'd2);

    p_dec_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && eff_dec && !eff_inc && !apply) |=> $stable(now));
endmodule

// File: rtl/rtc_cal_hostif.sv
`timescale 1ns/1ps
module rtc_cal_hostif
    import rtc_cal_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h2010,
    parameter logic [ADDR_W-1:0] GATE_ADDR = 16'h201F,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              ready,
    input  cal_t              live,
    input  logic              ack_tgl,
    output logic              req_tgl,
    output field_e            wr_field,
    output logic [7:0]        wr_data
);
    cal_t   snap;
    field_e off;
    logic   in_win, is_reg, is_gate, ack_s, busy;
    logic   rd_wait, gate_open, accept_wr, launch;

    rtc_cal_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk (clk), .rst (rst), .d (ack_tgl), .q (ack_s)
    );

    assign off       = field_e'(addr[2:0]);
    assign in_win    = (addr[ADDR_W-1:3] == BASE_ADDR[ADDR_W-1:3]);
    assign is_reg    = in_win && (off != F_STAT);
    assign is_gate   = (addr == GATE_ADDR);
    assign busy      = req_tgl ^ ack_s;

    always_comb begin
        if (!sel)                    ready = 1'b0;
        else if (!we)                ready = rd_wait;
        else if (is_reg && gate_open) ready = !busy;
        else                         ready = 1'b1;
    end

    assign accept_wr = sel && we && ready;
    assign launch    = accept_wr && is_reg && gate_open;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_wait   <= 1'b0;
            gate_open <= 1'b0;
            req_tgl   <= 1'b0;
            wr_field  <= F_SEC;
            wr_data   <= 8'd0;
            snap      <= CAL_RESET;
        end else begin
            rd_wait <= sel && !we && !rd_wait;
            if (sel && !we && !rd_wait && in_win && off == F_SEC) snap <= live;
            if (launch)                    gate_open <= 1'b0;
            else if (accept_wr && is_gate) gate_open <= 1'b1;
            if (launch) begin
                req_tgl  <= ~req_tgl;
                wr_field <= off;
                wr_data  <= wdata;
            end
        end
    end

    always_comb begin
        rdata = 8'd0;
        if (in_win) begin
            case (off)
                F_SEC:   rdata = snap.sec;
                F_MIN:   rdata = snap.min;
                F_HOUR:  rdata = snap.hour;
                F_WDAY:  rdata = snap.wday;
                F_MDAY:  rdata = snap.mday;
                F_MONTH: rdata = snap.month;
                F_YEAR:  rdata = snap.year;
                default: rdata = {6'd0, gate_open, busy};
            endcase
        end
    end

    p_read_one_wait_r5: assert property (@(posedge clk) disable iff (rst)
        (sel && !we && ready) |-> $past(sel && !we && !ready));

    p_gate_one_shot_r6: assert property (@(posedge clk) disable iff (rst)
        launch |=> !gate_open);

    p_busy_after_launch_r9: assert property (@(posedge clk) disable iff (rst)
        launch |=> busy);
endmodule

// File: rtl/rtc_cal.sv
`timescale 1ns/1ps
module rtc_cal
    import rtc_cal_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h2010,
    parameter logic [ADDR_W-1:0] GATE_ADDR = 16'h201F,
    parameter int TICK_DIV    = 32768,
    parameter int GAP_TICKS   = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              host_clk,
    input  logic              rtc_clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              bus_ready,
    input  logic              inc_sec_pulse,
    input  logic              dec_sec_pulse
);
    cal_t       live;
    field_e     wr_field;
    logic [7:0] wr_data;
    logic       req_tgl, ack_tgl, restart, sec_tick;

    rtc_cal_prescale #(.DIV(TICK_DIV)) u_prescale (
        .clk (rtc_clk), .rst (rst), .restart (restart), .strobe (sec_tick)
    );

    rtc_cal_core #(.GAP_TICKS(GAP_TICKS), .SYNC_STAGES(SYNC_STAGES)) u_core (
        .clk       (rtc_clk),
        .rst       (rst),
        .sec_tick  (sec_tick),
        .req_tgl   (req_tgl),
        .wr_field  (wr_field),
        .wr_data   (wr_data),
        .inc_pulse (inc_sec_pulse),
        .dec_pulse (dec_sec_pulse),
        .ack_tgl   (ack_tgl),
        .restart   (restart),
        .live      (live)
    );

    rtc_cal_hostif #(
        .ADDR_W (ADDR_W), .BASE_ADDR (BASE_ADDR),
        .GATE_ADDR (GATE_ADDR), .SYNC_STAGES (SYNC_STAGES)
    ) u_hostif (
        .clk      (host_clk),
        .rst      (rst),
        .sel      (bus_sel),
        .we       (bus_we),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .rdata    (bus_rdata),
        .ready    (bus_ready),
        .live     (live),
        .ack_tgl  (ack_tgl),
        .req_tgl  (req_tgl),
        .wr_field (wr_field),
        .wr_data  (wr_data)
    );
endmodule

// File: tb/rtc_cal_test.sv
`timescale 1ns/1ps
module rtc_cal_test;
    localparam int DIV = 256;
    localparam logic [15:0] BASE = 16'h2010;
    localparam logic [15:0] GATE = 16'h201F;
    localparam logic [15:0] A_SEC = BASE + 16'd0, A_MIN = BASE + 16'd1, A_HOUR = BASE + 16'd2,
                            A_WDAY = BASE + 16'd3, A_MDAY = BASE + 16'd4, A_MON = BASE + 16'd5,
                            A_YEAR = BASE + 16'd6, A_STAT = BASE + 16'd7;

    typedef struct packed {
        logic [7:0] s, m, h, w, d, mo, y;
    } tm_t;
    typedef struct packed {
        tm_t  st;
        logic inc;
        logic dec;
        tm_t  ex;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{'{30, 20, 10, 3, 15,  6, 23}, 1'b0, 1'b0, '{31, 20, 10, 3, 15,  6, 23}}, // R1 plain step
        '{'{59, 20, 10, 3, 15,  6, 23}, 1'b0, 1'b0, '{ 0, 21, 10, 3, 15,  6, 23}}, // R1 minute carry
        '{'{59, 59, 23, 7, 30,  4, 23}, 1'b0, 1'b0, '{ 0,  0,  0, 1,  1,  5, 23}}, // R2 30-day month
        '{'{59, 59, 23, 2, 28,  2, 24}, 1'b0, 1'b0, '{ 0,  0,  0, 3, 29,  2, 24}}, // R2 leap Feb 28
        '{'{59, 59, 23, 2, 28,  2, 23}, 1'b0, 1'b0, '{ 0,  0,  0, 3,  1,  3, 23}}, // R2 plain Feb 28
        '{'{59, 59, 23, 4, 29,  2, 24}, 1'b0, 1'b0, '{ 0,  0,  0, 5,  1,  3, 24}}, // R2 leap Feb 29
        '{'{59, 59, 23, 5, 31, 12, 99}, 1'b0, 1'b0, '{ 0,  0,  0, 6,  1,  1,  0}}, // R1 year wrap
        '{'{58, 20, 10, 3, 15,  6, 23}, 1'b1, 1'b0, '{ 0, 21, 10, 3, 15,  6, 23}}, // R10 inc carry
        '{'{30, 20, 10, 3, 15,  6, 23}, 1'b0, 1'b1, '{30, 20, 10, 3, 15,  6, 23}}, // R11 dec hold
        '{'{30, 20, 10, 3, 15,  6, 23}, 1'b1, 1'b1, '{31, 20, 10, 3, 15,  6, 23}}, // R12 cancel
        '{'{59, 59, 23, 1, 31,  1, 23}, 1'b1, 1'b0, '{ 1,  0,  0, 2,  1,  2, 23}}  // R10 inc over day
    };
    localparam int VREQ [NV] = '{1, 1, 2, 2, 2, 2, 1, 10, 11, 12, 10};

    logic        hclk = 1'b0, rclk = 1'b0, rst = 1'b1;
    logic        sel = 1'b0, we = 1'b0, inc = 1'b0, dec = 1'b0;
    logic [15:0] addr = 16'd0;
    logic [7:0]  wdata = 8'd0, rdata;
    logic        ready;
    int          checks = 0, errors = 0;
    bit          done = 1'b0;

    always #5  hclk = ~hclk;
    always #19 rclk = ~rclk;

    rtc_cal #(.TICK_DIV(DIV)) uut (
        .host_clk (hclk), .rtc_clk (rclk), .rst (rst),
        .bus_sel (sel), .bus_we (we), .bus_addr (addr), .bus_wdata (wdata),
        .bus_rdata (rdata), .bus_ready (ready),
        .inc_sec_pulse (inc), .dec_sec_pulse (dec)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic w, input logic [15:0] a, input logic [7:0] d,
                        output logic [7:0] q, output int waits);
        @(negedge hclk);
        sel = 1'b1; we = w; addr = a; wdata = d; waits = 0;
        #1;
        while (!ready) begin
            @(negedge hclk); #1;
            waits++;
        end
        q = rdata;
        @(posedge hclk); #1;
        sel = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] q);
        int w;
        xfer(1'b0, a, 8'd0, q, w);
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        logic [7:0] q; int w;
        xfer(1'b1, a, d, q, w);
    endtask

    task automatic wait_idle();
        logic [7:0] q;
        do rd(A_STAT, q); while (q[0]);
    endtask

    task automatic gwr(input logic [15:0] a, input logic [7:0] d);
        wr(GATE, 8'd0);
        wr(a, d);
        wait_idle();
    endtask

    task automatic read_all(output tm_t t);
        rd(A_SEC, t.s);  rd(A_MIN, t.m);  rd(A_HOUR, t.h); rd(A_WDAY, t.w);
        rd(A_MDAY, t.d); rd(A_MON, t.mo); rd(A_YEAR, t.y);
    endtask

    initial begin
        logic [7:0] q, q2;
        int         w;
        tm_t        t;
        repeat (100) @(posedge hclk);
        #1 rst = 1'b0;

        // R9 / R1 / R5: state out of reset
        rd(A_STAT, q);                 chk("R9 status after reset", q, 0);
        xfer(1'b0, A_SEC, 8'd0, q, w); chk("R1 reset seconds", q, 0);
        chk("R5 read wait states", w, 1);
        rd(A_WDAY, q); chk("R1 reset weekday", q, 1);
        rd(A_MDAY, q); chk("R1 reset day", q, 1);
        rd(A_MON, q);  chk("R1 reset month", q, 1);

        // R7: write with the gate closed
        xfer(1'b1, A_MIN, 8'd45, q, w); chk("R7 closed write no wait", w, 0);
        rd(A_STAT, q);                  chk("R7 no write in flight", q, 0);
        rd(A_SEC, q); rd(A_MIN, q);     chk("R7 minutes unchanged", q, 0);

        // R6: gate survives unrelated accesses, closes after one write
        wr(GATE, 8'd0);
        rd(A_SEC, q); rd(A_MDAY, q);
        wr(16'h3000, 8'h55);
        rd(A_STAT, q);                  chk("R6 gate still open", q[1], 1);
        wr(A_HOUR, 8'd7);
        wait_idle();
        rd(A_STAT, q);                  chk("R6 gate closed after write", q[1], 0);
        rd(A_SEC, q); rd(A_HOUR, q);    chk("R6 hour written", q, 7);
        wr(A_HOUR, 8'd9);
        rd(A_SEC, q); rd(A_HOUR, q);    chk("R7 second write ignored", q, 7);

        // R4: holding registers refresh only on a seconds read
        rd(A_SEC, q); rd(A_SEC, q2);    chk("R4 consecutive seconds agree", q2, q);
        gwr(A_HOUR, 8'd12);
        rd(A_HOUR, q);                  chk("R4 hour held without seconds read", q, 7);
        rd(A_SEC, q); rd(A_HOUR, q);    chk("R4 hour refreshed by seconds read", q, 12);

        // R8 / R9: second write held while first in flight
        wr(GATE, 8'd0);
        wr(A_MIN, 8'd1);
        rd(A_STAT, q);                  chk("R9 busy during write", q[0], 1);
        wr(GATE, 8'd0);
        xfer(1'b1, A_MIN, 8'd2, q, w);  chk("R8 write held off", (w > 0), 1);
        wait_idle();
        rd(A_SEC, q); rd(A_MIN, q);     chk("R8 held write applied", q, 2);

        // R3: seconds write restarts the one-second interval
        gwr(A_SEC, 8'd10);
        repeat (DIV / 2) @(posedge rclk);
        rd(A_SEC, q);                   chk("R3 no update before interval", q, 10);
        repeat (DIV) @(posedge rclk);
        rd(A_SEC, q);                   chk("R3 one update after interval", q, 11);

        // Vector table: preset, optional correction, one update, read back
        for (int i = 0; i < NV; i++) begin
            gwr(A_SEC, 8'd0);
            gwr(A_MIN, VECS[i].st.m);  gwr(A_HOUR, VECS[i].st.h);
            gwr(A_WDAY, VECS[i].st.w); gwr(A_MDAY, VECS[i].st.d);
            gwr(A_MON, VECS[i].st.mo); gwr(A_YEAR, VECS[i].st.y);
            gwr(A_SEC, VECS[i].st.s);
            @(negedge rclk); inc = VECS[i].inc; dec = VECS[i].dec;
            @(negedge rclk); inc = 1'b0; dec = 1'b0;
            repeat (DIV + DIV / 2) @(posedge rclk);
            read_all(t);
            chk($sformatf("R%0d vector %0d", VREQ[i], i), t, VECS[i].ex);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge hclk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule